// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the instruction fetch address register and guesses, in the same cycle, where fetch should go next. It combines a direction table of small counters with a cache of branch targets. Both are addressed by the low word-address bits of the program counter. When the target cache holds an entry whose tag matches the fetch address, and the direction counter for that slot leans towards taken, the cached target becomes the next fetch address at once. In every other case the next address is the sequential one, four bytes on.

Once a branch resolves later in the pipeline, its address, real direction and real target come back on the update inputs. The block compares what it would have predicted for that branch with what happened, and raises a mispredict flag in that same cycle so the pipeline can flush and redirect. It also trains the direction counter and, for taken branches, writes the target cache. A mode pin picks between one-bit history, which follows the last outcome, and two-bit saturating history, which needs two wrong guesses in a row before it changes direction. The lookup is purely combinational on the fetch address. Updates are plain strobes, accepted in every cycle with no back-pressure, because a resolved branch cannot be held back.

Top module: `bp_predictor`

## Requirements
- R1: After reset every direction counter holds 2'b01 (weak not-taken) and every target cache entry is invalid. Every fetch address then predicts not-taken, with next PC = fetch PC + 4.
- R2: The slot index is PC bits [7:2] and the tag is PC bits [31:8]. Two addresses with the same index but different tags never hit each other's target entry.
- R3: When the target entry for the fetch PC is valid with a matching tag and the counter's upper bit is 1, pred_taken is 1 and pred_next_pc is the stored target in the same cycle.
- R4: In every other case pred_taken is 0 and pred_next_pc is fetch PC + 4.
- R5: In two-bit mode (mode_two_bit=1) a taken outcome increments the counter and a not-taken outcome decrements it, saturating at 2'b11 and 2'b00. A taken prediction therefore flips only after two successive not-taken outcomes.
- R6: In one-bit mode (mode_two_bit=0) the counter is set to 2'b11 on a taken outcome and 2'b00 on a not-taken outcome, so the prediction flips after a single wrong guess.
- R7: A valid update with upd_taken=1 writes the slot's target entry (valid, tag of upd_pc, upd_target), overwriting whatever it held.
- R8: A not-taken update never writes the target cache; an entry held by another branch in the same slot stays usable.
- R9: mispredict is high only in a cycle with upd_valid=1 where the actual next PC (upd_target if taken, else upd_pc + 4) differs from the next PC the pre-update state predicts for upd_pc. When upd_valid=0 the update inputs change nothing.
- R10: Updates take effect from the next clock edge; lookups in the update cycle still see the old state.
- R11: The sequential address wraps modulo 2^32 (0xFFFFFFFC predicts 0x00000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_two_bit | input | 1 | 1: two-bit saturating history, 0: one-bit history |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Prediction redirects to a cached target |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | 32 | Actual target of the resolved branch |
| mispredict | output | 1 | The resolved branch was predicted wrongly |

## Verification
A corrupted counter or target entry becomes visible at the ports one cycle after the update that wrote it. It shows either on pred_next_pc when the same address is fetched, or on mispredict when that branch resolves again. Hysteresis faults only appear after specific outcome sequences, so the stimulus drives a single slot through saturation in both directions and through single and double wrong guesses in each mode. Aliasing branches share a slot to expose tag or allocation faults, and a re-reset shows whether any state survives.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int PC_W_DEF  = 32;
  localparam int IDX_W_DEF = 6;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken, input logic two_bit);
    ctr_t nxt;
    if (!two_bit) begin
      nxt = taken ? 2'b11 : 2'b00;
    end else if (taken) begin
      nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    end else begin
      nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    end
    return nxt;
  endfunction
endpackage

// File: rtl/bp_history.sv
module bp_history
  import bp_pkg::*;
#(
  parameter int IDX_W = IDX_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr_t             rd_a_ctr,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr_t             rd_b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_ctr;
    end
  end

  assign rd_a_ctr = ctr_q[rd_a_idx];
  assign rd_b_ctr = ctr_q[rd_b_idx];
endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int TAG_W = PC_W - IDX_W - 2,
  parameter int PORTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx [PORTS],
  input  logic [TAG_W-1:0] lk_tag [PORTS],
  output logic             lk_hit [PORTS],
  output logic [PC_W-1:0]  lk_tgt [PORTS],
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) vld_q[i] <= 1'b0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_lookup
    assign lk_hit[p] = vld_q[lk_idx[p]] && (tag_q[lk_idx[p]] == lk_tag[p]);
    assign lk_tgt[p] = tgt_q[lk_idx[p]];
  end
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int PC_W  = PC_W_DEF,
  parameter int IDX_W = IDX_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_two_bit,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_next_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  output logic            mispredict
);
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int P_F   = 0;
  localparam int P_U   = 1;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  ctr_t             f_ctr, u_ctr, u_ctr_nxt;
  logic [IDX_W-1:0] lk_idx [2];
  logic [TAG_W-1:0] lk_tag [2];
  logic             lk_hit [2];
  logic [PC_W-1:0]  lk_tgt [2];
  logic             f_hit, u_hit;
  logic [PC_W-1:0]  f_seq, u_seq, u_pred_next, u_actual_next;

  assign f_idx = fetch_pc[IDX_W+1:2];
  assign f_tag = fetch_pc[PC_W-1:IDX_W+2];
  assign u_idx = upd_pc[IDX_W+1:2];
  assign u_tag = upd_pc[PC_W-1:IDX_W+2];

  assign lk_idx[P_F] = f_idx;
  assign lk_tag[P_F] = f_tag;
  assign lk_idx[P_U] = u_idx;
  assign lk_tag[P_U] = u_tag;
  assign f_hit = lk_hit[P_F];
  assign u_hit = lk_hit[P_U];

  bp_history #(.IDX_W(IDX_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (f_idx),
    .rd_a_ctr (f_ctr),
    .rd_b_idx (u_idx),
    .rd_b_ctr (u_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (u_idx),
    .wr_ctr   (u_ctr_nxt)
  );

  bp_target_buf #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .PORTS(2)) u_tbuf (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_idx (lk_idx),
    .lk_tag (lk_tag),
    .lk_hit (lk_hit),
    .lk_tgt (lk_tgt),
    .wr_en  (upd_valid && upd_taken),
    .wr_idx (u_idx),
    .wr_tag (u_tag),
    .wr_tgt (upd_target)
  );

  // fetch side
  assign f_seq        = fetch_pc + PC_W'(4);
  assign pred_taken   = f_hit && f_ctr[1];
  assign pred_next_pc = pred_taken ? lk_tgt[P_F] : f_seq;

  // resolve side: re-derive the prediction from pre-update state
  assign u_seq         = upd_pc + PC_W'(4);
  assign u_pred_next   = (u_hit && u_ctr[1]) ? lk_tgt[P_U] : u_seq;
  assign u_actual_next = upd_taken ? upd_target : u_seq;
  assign mispredict    = upd_valid && (u_pred_next != u_actual_next);
  assign u_ctr_nxt     = ctr_next(u_ctr, upd_taken, mode_two_bit);
endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_taken,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            mispredict,
  input logic            u_hit
);
  // R1: first cycle out of reset nothing is cached
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !pred_taken);

  // R9: no flag without a resolved branch
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !mispredict);

  // R7: a taken branch that redirects next cycle must use the target just written
  a_r7_alloc_target: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      (fetch_pc != $past(upd_pc) || !pred_taken || pred_next_pc == $past(upd_target)));

  // R8: a not-taken branch that missed must still miss afterwards
  a_r8_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !u_hit) |=> (fetch_pc != $past(upd_pc) || !pred_taken));

  // R5: a correctly predicted taken branch keeps predicting taken
  a_r5_taken_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && fetch_pc == upd_pc && pred_taken) |=>
      (fetch_pc != $past(upd_pc) || pred_taken));
endmodule

bind bp_predictor bp_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_pc     (fetch_pc),
  .pred_taken   (pred_taken),
  .upd_valid    (upd_valid),
  .upd_pc       (upd_pc),
  .upd_taken    (upd_taken),
  .upd_target   (upd_target),
  .pred_next_pc (pred_next_pc),
  .mispredict   (mispredict),
  .u_hit        (u_hit)
);

// File: tb/bp_predictor_test.sv
module bp_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_two_bit = 1'b1;
  logic [31:0] fetch_pc = '0;
  logic [31:0] pred_next_pc;
  logic        pred_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic        mispredict;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bp_predictor uut (
    .clk(clk), .rst_n(rst_n), .mode_two_bit(mode_two_bit),
    .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .mispredict(mispredict)
  );

  localparam logic [31:0] PA = 32'h0000_1040; // slot 16
  localparam logic [31:0] PB = 32'h0000_1140; // slot 16, other tag
  localparam logic [31:0] PE = 32'h0000_1200; // slot 0
  localparam logic [31:0] PF = 32'hFFFF_FFFC; // slot 63
  localparam logic [31:0] TA = 32'h0000_2000;
  localparam logic [31:0] TB = 32'h0000_3000;
  localparam logic [31:0] TE = 32'h0000_0400;

  typedef struct packed {
    logic        mode;
    logic [31:0] fpc;
    logic [31:0] exp_next;
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] utgt;
    logic        exp_mis;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1, PA, 32'h1044, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd4},  // R4 empty
    '{1'b1, PA, 32'h1044, 1'b1, PA,    1'b1, TA,    1'b1, 8'd9},  // R9 miss->taken
    '{1'b1, PA, TA,       1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd3},  // R3 hit taken
    '{1'b1, PA, TA,       1'b1, PA,    1'b0, 32'h0, 1'b1, 8'd10}, // R10 old state
    '{1'b1, PA, 32'h1044, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd5},  // R5 ctr 01
    '{1'b1, PA, 32'h1044, 1'b1, PA,    1'b1, TA,    1'b1, 8'd5},  // R5 ->10
    '{1'b1, PA, TA,       1'b1, PA,    1'b1, TA,    1'b0, 8'd5},  // R5 ->11
    '{1'b1, PA, TA,       1'b1, PA,    1'b1, TA,    1'b0, 8'd5},  // R5 saturate 11
    '{1'b1, PA, TA,       1'b1, PA,    1'b0, 32'h0, 1'b1, 8'd5},  // R5 ->10
    '{1'b1, PA, TA,       1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd5},  // R5 one miss holds
    '{1'b1, PA, TA,       1'b1, PA,    1'b0, 32'h0, 1'b1, 8'd5},  // R5 ->01
    '{1'b1, PA, 32'h1044, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd5},  // R5 flipped
    '{1'b1, PB, 32'h1144, 1'b1, PA,    1'b1, TA,    1'b1, 8'd2},  // R2 ->10
    '{1'b1, PB, 32'h1144, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd2},  // R2 tag miss
    '{1'b1, PA, TA,       1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd2},  // R2 owner hits
    '{1'b1, PA, TA,       1'b1, PA,    1'b1, TA,    1'b0, 8'd5},  // R5 ->11
    '{1'b1, PA, TA,       1'b1, PB,    1'b0, 32'h0, 1'b0, 8'd8},  // R8 B not-taken
    '{1'b1, PA, TA,       1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd8},  // R8 A intact
    '{1'b1, PB, 32'h1144, 1'b1, PB,    1'b1, TB,    1'b1, 8'd7},  // R7 overwrite
    '{1'b1, PB, TB,       1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd7},  // R7 new owner
    '{1'b1, PA, 32'h1044, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd7},  // R7 old owner gone
    '{1'b0, PE, 32'h1204, 1'b1, PE,    1'b1, TE,    1'b1, 8'd6},  // R6 ->11
    '{1'b0, PE, TE,       1'b1, PE,    1'b0, 32'h0, 1'b1, 8'd6},  // R6 ->00
    '{1'b0, PE, 32'h1204, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd6},  // R6 flipped once
    '{1'b0, PE, 32'h1204, 1'b1, PE,    1'b1, TE,    1'b1, 8'd6},  // R6 ->11
    '{1'b0, PE, TE,       1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd6},  // R6 flipped back
    '{1'b1, PF, 32'h0,    1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 8'd11}  // R11 wrap
  };

  task automatic check32(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [31:0] f, input logic uv,
                       input logic [31:0] up, input logic ut, input logic [31:0] tg);
    @(negedge clk);
    mode_two_bit = m; fetch_pc = f; upd_valid = uv;
    upd_pc = up; upd_taken = ut; upd_target = tg;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    drive(1'b1, PA, 1'b0, '0, 1'b0, '0);
    check32("R1", "pred_taken", {31'b0, pred_taken}, 32'h0);
    check32("R1", "pred_next_pc", pred_next_pc, 32'h1044);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].mode, VEC[i].fpc, VEC[i].uv, VEC[i].upc, VEC[i].ut, VEC[i].utgt);
      check32($sformatf("R%0d row%0d", VEC[i].req, i), "pred_next_pc", pred_next_pc,
              VEC[i].exp_next);
      check32($sformatf("R%0d row%0d", VEC[i].req, i), "mispredict", {31'b0, mispredict},
              {31'b0, VEC[i].exp_mis});
    end

    // R1: re-reset clears trained state (PB held target TB, PE held TE)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, PB, 1'b0, '0, 1'b0, '0);
    check32("R1", "re-reset PB", pred_next_pc, 32'h1144);
    drive(1'b1, PE, 1'b0, '0, 1'b0, '0);
    check32("R1", "re-reset PE", pred_next_pc, 32'h1204);
    check32("R1", "re-reset taken", {31'b0, pred_taken}, 32'h0);

    // R9: invalid update is ignored (one-bit mode would flip on a real one)
    drive(1'b0, PA, 1'b1, PA, 1'b1, TA);
    check32("R9", "train mispredict", {31'b0, mispredict}, 32'h1);
    drive(1'b0, PA, 1'b0, PA, 1'b0, 32'h0);
    check32("R9", "idle mispredict", {31'b0, mispredict}, 32'h0);
    check32("R3", "hit after train", pred_next_pc, TA);
    drive(1'b0, PA, 1'b0, '0, 1'b0, '0);
    check32("R9", "state untouched", pred_next_pc, TA);
    check32("R3", "pred_taken", {31'b0, pred_taken}, 32'h1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule